// File: doc/BRIEF.md
# Block Cipher Chaining-Mode Controller

This block wraps an iterative 64-bit block cipher and applies one of four chaining modes to a stream of 64-bit blocks: electronic codebook, cipher block chaining, output feedback and counter. A host selects the mode and the direction, loads an initialization vector (or a starting counter value) once, and then feeds blocks through a valid/ready handshake. Each accepted block produces exactly one 64-bit result, marked by a single-cycle valid pulse.

The cipher keeps its own key register. A key is written once, and any number of blocks then run without rewriting it. The controller holds a 64-bit chaining register across blocks. It latches the mode, the direction and the input block when a block is accepted. It forms the cipher's input and direction from these, and when the cipher finishes it combines the cipher result with the latched context to produce the output and the next chaining value.

Top module: `blk_mode_ctrl`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: A block accepted at a clock edge (in_valid_i and in_ready_o both high) gives out_valid_o high for exactly one cycle, ROUNDS+1 edges later. in_ready_o stays low from the acceptance edge through the output cycle and is high again on the next cycle.
- R3: Mode encoding on mode_i is 0 = codebook, 1 = block chaining, 2 = output feedback, 3 = counter. The cipher's forward transform with key K applies, for r = 0 to ROUNDS-1, x = rotl(x + k_r, 7) mod 2^64, with k_r = rotl(K, (5*r) mod 64) XOR r. In mode 0 with decrypt_i = 0, the output is this transform of the input block.
- R4: In mode 0 with decrypt_i = 1, the output is the inverse transform, x = rotl(x, 57) - k_r for r = ROUNDS-1 down to 0, which recovers the plaintext.
- R5: In mode 1 with decrypt_i = 0, the output is the forward transform of (input XOR chain), and that output becomes the new chain value.
- R6: In mode 1 with decrypt_i = 1, the output is the inverse transform of the input XOR the chain value, and the input block becomes the new chain value.
- R7: In mode 2, the output is forward(chain) XOR input, and forward(chain) becomes the new chain value. decrypt_i has no effect in this mode.
- R8: In mode 3, the output is forward(chain) XOR input, and the chain then increments by one modulo 2^64, so an all-ones counter wraps to zero.
- R9: A pulse on iv_load_i writes iv_i into the chain register when no block is in flight. While a block is in flight the pulse is ignored, and the result and the next chain value use the old chain.
- R10: key_load_i stores key_i when no block is in flight, and successive blocks use the stored key without a reload. While a block is in flight key_load_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Chaining mode select |
| decrypt_i | input | 1 | 1 selects decryption (used in modes 0 and 1) |
| key_i | input | 64 | Key value |
| key_load_i | input | 1 | Key write strobe |
| iv_i | input | 64 | Initialization vector or starting counter |
| iv_load_i | input | 1 | Chain register write strobe |
| in_valid_i | input | 1 | Input block valid |
| in_ready_o | output | 1 | Block can be accepted |
| in_data_i | input | 64 | Input block |
| out_valid_o | output | 1 | One-cycle result strobe |
| out_data_o | output | 64 | Result block |

## Verification
The assertions assume the host never holds iv_load_i high while it expects a block to be accepted, because a pending load blocks in_ready_o in that cycle. They also assume reset is applied before the first block. The counter-step and chain-hold properties rely on the chain register changing only on an IV load or at block completion. The bench raises in_valid_i only on cycles where it has already seen in_ready_o high, pulses each load strobe for one cycle, and places the loads it wants ignored on the cycle just after acceptance, when the cipher is certainly busy.

// File: rtl/blk_mode_pkg.sv
package blk_mode_pkg;
  localparam int unsigned BLK_W = 64;

  typedef enum logic [1:0] {
    MODE_ECB = 2'd0,
    MODE_CBC = 2'd1,
    MODE_OFB = 2'd2,
    MODE_CTR = 2'd3
  } chain_mode_e;

  function automatic logic [BLK_W-1:0] rotl64(logic [BLK_W-1:0] x, logic [5:0] s);
    logic [6:0] rs;
    rs = 7'd64 - {1'b0, s};
    return (s == 6'd0) ? x : ((x << s) | (x >> rs));
  endfunction
endpackage

// File: rtl/blk_mode_core.sv
module blk_mode_core
  import blk_mode_pkg::*;
#(
  parameter int unsigned ROUNDS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BLK_W-1:0] key_i,
  input  logic             key_load_i,
  input  logic             start_i,
  input  logic             decrypt_i,
  input  logic [BLK_W-1:0] data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [BLK_W-1:0] data_o
);
  localparam int unsigned CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);
  localparam logic [5:0] ROT_F = 6'd7;
  localparam logic [5:0] ROT_B = 6'd57;

  logic [BLK_W-1:0] key_q, st_q, st_next, rkey;
  logic [CNT_W-1:0] cnt_q, rnd_idx;
  logic             dir_q, busy_q, done_q;
  logic [5:0]       rk_rot;

  assign rnd_idx = dir_q ? (LAST - cnt_q) : cnt_q;
  assign rk_rot  = 6'(rnd_idx) * 6'd5;
  assign rkey    = rotl64(key_q, rk_rot) ^ BLK_W'(rnd_idx);
  assign st_next = dir_q ? (rotl64(st_q, ROT_B) - rkey) : rotl64(st_q + rkey, ROT_F);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q  <= '0;
      st_q   <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (key_load_i && !busy_q) key_q <= key_i;
      if (start_i && !busy_q) begin
        st_q   <= data_i;
        cnt_q  <= '0;
        dir_q  <= decrypt_i;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        st_q  <= st_next;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign data_o = st_q;

  // R10: stored key cannot move while rounds run
  a_r10_key_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(key_q));
  // R2: completion only ends a busy phase
  a_r2_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(busy_q));
  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/blk_mode_mix.sv
module blk_mode_mix
  import blk_mode_pkg::*;
(
  input  chain_mode_e      pre_mode_i,
  input  logic             pre_dec_i,
  input  logic [BLK_W-1:0] pre_data_i,
  input  chain_mode_e      post_mode_i,
  input  logic             post_dec_i,
  input  logic [BLK_W-1:0] post_data_i,
  input  logic [BLK_W-1:0] chain_i,
  input  logic [BLK_W-1:0] core_out_i,
  output logic [BLK_W-1:0] core_in_o,
  output logic             core_dec_o,
  output logic [BLK_W-1:0] result_o,
  output logic [BLK_W-1:0] chain_next_o
);
  always_comb begin
    unique case (pre_mode_i)
      MODE_ECB: begin core_in_o = pre_data_i; core_dec_o = pre_dec_i; end
      MODE_CBC: begin
        core_in_o  = pre_dec_i ? pre_data_i : (pre_data_i ^ chain_i);
        core_dec_o = pre_dec_i;
      end
      default:  begin core_in_o = chain_i; core_dec_o = 1'b0; end
    endcase
  end

  always_comb begin
    unique case (post_mode_i)
      MODE_ECB: begin result_o = core_out_i; chain_next_o = chain_i; end
      MODE_CBC: begin
        if (post_dec_i) begin
          result_o     = core_out_i ^ chain_i;
          chain_next_o = post_data_i;
        end else begin
          result_o     = core_out_i;
          chain_next_o = core_out_i;
        end
      end
      MODE_OFB: begin result_o = core_out_i ^ post_data_i; chain_next_o = core_out_i; end
      default:  begin result_o = core_out_i ^ post_data_i; chain_next_o = chain_i + 1'b1; end
    endcase
  end
endmodule

// File: rtl/blk_mode_ctrl.sv
module blk_mode_ctrl
  import blk_mode_pkg::*;
#(
  parameter int unsigned ROUNDS = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  mode_i,
  input  logic        decrypt_i,
  input  logic [63:0] key_i,
  input  logic        key_load_i,
  input  logic [63:0] iv_i,
  input  logic        iv_load_i,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [63:0] in_data_i,
  output logic        out_valid_o,
  output logic [63:0] out_data_o
);
  chain_mode_e      ctx_mode_q;
  logic             ctx_dec_q, out_valid_q;
  logic [BLK_W-1:0] ctx_data_q, chain_q, out_data_q;
  logic [BLK_W-1:0] core_in, core_out, result, chain_next;
  logic             core_dec, core_busy, core_done, accept, iv_ok;

  assign in_ready_o = !core_busy && !core_done && !out_valid_q && !iv_load_i;
  assign accept     = in_valid_i && in_ready_o;
  assign iv_ok      = iv_load_i && !core_busy && !core_done;

  blk_mode_mix i_mix (
    .pre_mode_i   (chain_mode_e'(mode_i)),
    .pre_dec_i    (decrypt_i),
    .pre_data_i   (in_data_i),
    .post_mode_i  (ctx_mode_q),
    .post_dec_i   (ctx_dec_q),
    .post_data_i  (ctx_data_q),
    .chain_i      (chain_q),
    .core_out_i   (core_out),
    .core_in_o    (core_in),
    .core_dec_o   (core_dec),
    .result_o     (result),
    .chain_next_o (chain_next)
  );

  blk_mode_core #(.ROUNDS(ROUNDS)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_i      (key_i),
    .key_load_i (key_load_i),
    .start_i    (accept),
    .decrypt_i  (core_dec),
    .data_i     (core_in),
    .busy_o     (core_busy),
    .done_o     (core_done),
    .data_o     (core_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_mode_q  <= MODE_ECB;
      ctx_dec_q   <= 1'b0;
      ctx_data_q  <= '0;
      chain_q     <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= core_done;
      if (accept) begin
        ctx_mode_q <= chain_mode_e'(mode_i);
        ctx_dec_q  <= decrypt_i;
        ctx_data_q <= in_data_i;
      end
      if (core_done) begin
        out_data_q <= result;
        chain_q    <= chain_next;
      end else if (iv_ok) begin
        chain_q <= iv_i;
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;

  a_r2_out_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_q |=> !out_valid_q);
  a_r2_no_ready_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_busy |-> !in_ready_o);
  a_r2_out_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_q) |-> $past(core_done));
  a_r8_ctr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_q && ctx_mode_q == MODE_CTR) |-> (chain_q == $past(chain_q) + 64'd1));
  a_r9_chain_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_busy |=> $stable(chain_q));
endmodule

// File: tb/test_blk_mode_ctrl.sv
module test_blk_mode_ctrl;
  localparam int ROUNDS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        dec = 1'b0;
  logic [63:0] key = '0, iv = '0, din = '0;
  logic        key_load = 1'b0, iv_load = 1'b0, in_valid = 1'b0;
  logic        in_ready, out_valid;
  logic [63:0] dout;

  int checks = 0;
  int fails = 0;

  always #2ns clk = ~clk;

  blk_mode_ctrl #(.ROUNDS(ROUNDS)) i_blk_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .decrypt_i(dec),
    .key_i(key), .key_load_i(key_load), .iv_i(iv), .iv_load_i(iv_load),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(din),
    .out_valid_o(out_valid), .out_data_o(dout)
  );

  function automatic logic [63:0] rl(logic [63:0] x, int s);
    int m = s % 64;
    return (m == 0) ? x : ((x << m) | (x >> (64 - m)));
  endfunction
  function automatic logic [63:0] rk(logic [63:0] k, int r);
    return rl(k, (5 * r) % 64) ^ 64'(r);
  endfunction
  function automatic logic [63:0] fwd(logic [63:0] x, logic [63:0] k);
    logic [63:0] y = x;
    for (int r = 0; r < ROUNDS; r++) y = rl(y + rk(k, r), 7);
    return y;
  endfunction
  function automatic logic [63:0] inv(logic [63:0] x, logic [63:0] k);
    logic [63:0] y = x;
    for (int r = ROUNDS - 1; r >= 0; r--) y = rl(y, 57) - rk(k, r);
    return y;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_key(input logic [63:0] k);
    @(negedge clk); key = k; key_load = 1'b1;
    @(negedge clk); key_load = 1'b0;
  endtask

  task automatic load_iv(input logic [63:0] v);
    @(negedge clk); iv = v; iv_load = 1'b1;
    @(negedge clk); iv_load = 1'b0;
  endtask

  // inj: 0 none, 1 iv load while busy, 2 key load while busy
  task automatic run_block(input logic [1:0] m, input logic d, input logic [63:0] x,
                           input int inj, input logic [63:0] inj_v, output logic [63:0] y);
    int n = 0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready before block", 64'(in_ready), 64'd1);
    mode = m; dec = d; din = x; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R2 ready low after accept", 64'(in_ready), 64'd0);
    if (inj == 1) begin iv = inj_v; iv_load = 1'b1; end
    if (inj == 2) begin key = inj_v; key_load = 1'b1; end
    while (n < 100) begin
      @(negedge clk);
      iv_load = 1'b0; key_load = 1'b0;
      n++;
      if (out_valid) break;
    end
    chk(n == ROUNDS + 1, "R2 latency", 64'(n), 64'(ROUNDS + 1));
    chk(in_ready == 1'b0, "R2 ready low in output cycle", 64'(in_ready), 64'd0);
    y = dout;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 single-cycle valid", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R2 ready returns", 64'(in_ready), 64'd1);
  endtask

  localparam logic [63:0] K1 = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] K2 = 64'hFEDC_BA98_7654_3210;

  task automatic t_reset;
    #1ns;
    chk(out_valid == 1'b0, "R1 out_valid reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1 in_ready reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_ecb;
    logic [63:0] y, p;
    load_key(K1);
    p = 64'h0000_0000_0000_0000;
    run_block(2'd0, 1'b0, p, 0, 0, y);
    chk(y == fwd(p, K1), "R3 ecb enc zero", y, fwd(p, K1));
    p = 64'hDEAD_BEEF_CAFE_F00D;
    run_block(2'd0, 1'b0, p, 0, 0, y);
    chk(y == fwd(p, K1), "R3 R10 ecb enc second block same key", y, fwd(p, K1));
    run_block(2'd0, 1'b1, fwd(p, K1), 0, 0, y);
    chk(y == p, "R4 ecb dec recovers", y, p);
  endtask

  task automatic t_cbc;
    logic [63:0] pt[3];
    logic [63:0] ct[3];
    logic [63:0] y, c;
    logic [63:0] v = 64'h1111_2222_3333_4444;
    pt[0] = 64'h0; pt[1] = 64'h5555_AAAA_5555_AAAA; pt[2] = 64'hFFFF_0000_1234_5678;
    load_iv(v);
    c = v;
    for (int i = 0; i < 3; i++) begin
      run_block(2'd1, 1'b0, pt[i], 0, 0, y);
      c = fwd(pt[i] ^ c, K1);
      ct[i] = y;
      chk(y == c, "R5 cbc enc chain", y, c);
    end
    load_iv(v);
    for (int i = 0; i < 3; i++) begin
      run_block(2'd1, 1'b1, ct[i], 0, 0, y);
      chk(y == pt[i], "R6 cbc dec chain", y, pt[i]);
    end
  endtask

  task automatic t_ofb;
    logic [63:0] y, s;
    logic [63:0] v = 64'h0F0F_0F0F_F0F0_F0F0;
    logic [63:0] p0 = 64'h1234_0000_ABCD_0000;
    logic [63:0] p1 = 64'h0000_9999_0000_7777;
    logic [63:0] c0, c1;
    load_iv(v);
    s = fwd(v, K1);
    run_block(2'd2, 1'b0, p0, 0, 0, c0);
    chk(c0 == (s ^ p0), "R7 ofb block0", c0, s ^ p0);
    s = fwd(s, K1);
    run_block(2'd2, 1'b0, p1, 0, 0, c1);
    chk(c1 == (s ^ p1), "R7 ofb block1", c1, s ^ p1);
    load_iv(v);
    run_block(2'd2, 1'b1, c0, 0, 0, y);
    chk(y == p0, "R7 ofb decrypt_i ignored block0", y, p0);
    run_block(2'd2, 1'b1, c1, 0, 0, y);
    chk(y == p1, "R7 ofb decrypt_i ignored block1", y, p1);
  endtask

  task automatic t_ctr;
    logic [63:0] y, e;
    logic [63:0] p = 64'hA5A5_A5A5_5A5A_5A5A;
    load_iv(64'hFFFF_FFFF_FFFF_FFFE);
    run_block(2'd3, 1'b0, p, 0, 0, y);
    e = fwd(64'hFFFF_FFFF_FFFF_FFFE, K1) ^ p;
    chk(y == e, "R8 ctr first", y, e);
    run_block(2'd3, 1'b1, p, 0, 0, y);
    e = fwd(64'hFFFF_FFFF_FFFF_FFFF, K1) ^ p;
    chk(y == e, "R8 ctr increment", y, e);
    run_block(2'd3, 1'b0, p, 0, 0, y);
    e = fwd(64'h0, K1) ^ p;
    chk(y == e, "R8 ctr wrap to zero", y, e);
  endtask

  task automatic t_iv_busy;
    logic [63:0] y, c;
    logic [63:0] a = 64'h7777_0000_7777_0000;
    logic [63:0] b = 64'h0000_8888_0000_8888;
    logic [63:0] p = 64'h3141_5926_5358_9793;
    load_iv(a);
    run_block(2'd1, 1'b0, p, 1, b, y);
    c = fwd(p ^ a, K1);
    chk(y == c, "R9 iv load ignored while busy", y, c);
    run_block(2'd1, 1'b0, p, 0, 0, y);
    chk(y == fwd(p ^ c, K1), "R9 chain kept after ignored load", y, fwd(p ^ c, K1));
    load_iv(b);
    run_block(2'd1, 1'b0, p, 0, 0, y);
    chk(y == fwd(p ^ b, K1), "R9 iv load when idle", y, fwd(p ^ b, K1));
  endtask

  task automatic t_key_busy;
    logic [63:0] y;
    logic [63:0] p = 64'h2718_2818_2845_9045;
    run_block(2'd0, 1'b0, p, 2, K2, y);
    chk(y == fwd(p, K1), "R10 key load ignored in flight", y, fwd(p, K1));
    run_block(2'd0, 1'b0, p, 0, 0, y);
    chk(y == fwd(p, K1), "R10 stored key unchanged", y, fwd(p, K1));
    load_key(K2);
    run_block(2'd0, 1'b0, p, 0, 0, y);
    chk(y == fwd(p, K2), "R10 key load when idle", y, fwd(p, K2));
  endtask

  initial begin
    #200ns;
    @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    #150ns;
    t_reset();
    @(posedge rst_n);
    t_ecb();
    t_cbc();
    t_ofb();
    t_ctr();
    t_iv_busy();
    t_key_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800us;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule